// File: doc/BRIEF.md
# Strap Option Sampler

This block reads three slow configuration straps that set a touch controller's behaviour: one selects the acquisition speed and two select how long a continuous detection may last before a key is recalibrated, or a flip-flop output behaviour. The strap pins are synchronised and sampled several times, one sample every few microseconds, before a new value is accepted. A read in which even one sample differs is thrown away. The first read starts straight after reset. Further reads come after a long interval, but only when no key is detecting.

The block decodes the accepted straps into a speed flag, a timeout selection and a toggle enable, and holds them in registers for the rest of the chip. An options-valid flag rises after the first read that passes.

The block also watches the external active-low reset pin. A low period that lasts long enough, followed by a release, produces a one-cycle recalibrate-all pulse. The same pulse is produced once when the synchronous reset is released.

Top module: `strap_option_sampler`

## Requirements
- R1: While `rst` is high, `opts_valid` and `recal_all` are 0. A read starts as soon as `rst` falls. `opts_valid` stays 0 until the first read in which all samples agree. After that it stays 1.
- R2: A read takes SAMPLES samples of the synchronised straps. Samples are SAMPLE_GAP_US microsecond ticks apart, and the first sample is taken on the first tick of the read. The value is accepted only if every sample equals the first one.
- R3: A read that sees any disagreement ends at once and leaves the previous options unchanged. The next attempt comes after the reread interval.
- R4: A new read begins REREAD_US microsecond ticks after the previous read ended, but only while `any_detect` is 0. If `any_detect` is 1 when the interval expires, the read waits until it falls.
- R5: Speed strap low gives `speed_slow` = 0 (fast mode). Speed strap high gives `speed_slow` = 1 (slow, sync-capable mode).
- R6: The timeout straps (`strap_tmo_a`, `strap_tmo_b`) decode as follows, with `tmo_sel` encoded as 0 = 10 s, 1 = 60 s and 2 = infinite. (1,0) gives `tmo_sel` 0 and `toggle_en` 0. (0,1) gives `tmo_sel` 1 and `toggle_en` 0. (1,1) gives `tmo_sel` 0 and `toggle_en` 1. (0,0) gives `tmo_sel` 2 and `toggle_en` 0.
- R7: Holding `rst_pin_n` low for at least MIN_LOW_US microsecond ticks and then releasing it produces exactly one `recal_all` pulse. A shorter low period produces none.
- R8: Releasing `rst` produces exactly one `recal_all` pulse.
- R9: `recal_all` is never high for two cycles in a row.
- R10: The decoded option outputs change only when a read completes with all samples in agreement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| strap_speed | input | 1 | Speed strap pin (asynchronous) |
| strap_tmo_a | input | 1 | First timeout/toggle strap pin (asynchronous) |
| strap_tmo_b | input | 1 | Second timeout/toggle strap pin (asynchronous) |
| rst_pin_n | input | 1 | External active-low reset pin (asynchronous) |
| any_detect | input | 1 | High while any key channel is detecting |
| speed_slow | output | 1 | 1 = slow/sync mode, 0 = fast mode |
| tmo_sel | output | 2 | Timeout selection: 0 = 10 s, 1 = 60 s, 2 = infinite |
| toggle_en | output | 1 | Flip-flop output behaviour enabled |
| opts_valid | output | 1 | At least one read has been accepted |
| recal_all | output | 1 | One-cycle request to recalibrate every channel |

## Verification
The bench sweeps all eight strap combinations through the periodic reread. It also toggles one strap with a period that defeats every sample window: a design that accepted a majority, or that reported valid before a clean read, would publish the toggled value or raise `opts_valid` early. It holds `any_detect` high across a strap change, which catches a design that rereads during a detection. It drives reset-pin low periods just below and exactly at the threshold, with dense and sparse microsecond ticks, which exposes a length check that is off by one or that counts clock cycles instead of ticks.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    TMO_10S = 2'd0,
    TMO_60S = 2'd1,
    TMO_INF = 2'd2
  } tmo_e;

  typedef struct packed {
    logic slow;
    tmo_e tmo;
    logic toggle;
  } opts_t;

  // bit 2: speed strap, bit 1: timeout strap a, bit 0: timeout strap b
  typedef logic [2:0] raw_t;

  function automatic opts_t decode_straps(raw_t r);
    opts_t o;
    o.slow = r[2];
    unique case (r[1:0])
      2'b10, 2'b11: o.tmo = TMO_10S;
      2'b01:        o.tmo = TMO_60S;
      default:      o.tmo = TMO_INF;
    endcase
    o.toggle = r[1] & r[0];
    return o;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk) begin
      if (rst) stg <= {2{RST_VAL}};
      else     stg <= {stg[0], d[i]};
    end
    assign q[i] = stg[1];
  end
endmodule

// File: rtl/strap_read_ctrl.sv
module strap_read_ctrl
  import strap_pkg::*;
#(
  parameter int SAMPLES       = 25,
  parameter int SAMPLE_GAP_US = 10,
  parameter int REREAD_US     = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic any_detect,
  input  raw_t raw,
  output logic commit,
  output raw_t commit_val
);
  localparam int NW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam int GW = (SAMPLE_GAP_US > 1) ? $clog2(SAMPLE_GAP_US) : 1;
  localparam int PW = (REREAD_US > 1) ? $clog2(REREAD_US) : 1;
  localparam logic [NW-1:0] N_LAST   = NW'(SAMPLES - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(SAMPLE_GAP_US - 1);
  localparam logic [PW-1:0] PER_LAST = PW'(REREAD_US - 1);

  typedef enum logic {ST_WAIT, ST_READ} st_e;

  st_e           st;
  logic [NW-1:0] n;
  logic [GW-1:0] gap;
  logic [PW-1:0] per;
  raw_t          ref_val;
  logic          take;

  assign take = (st == ST_READ) && us_tick && (gap == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_READ;
      n          <= '0;
      gap        <= '0;
      per        <= '0;
      ref_val    <= '0;
      commit     <= 1'b0;
      commit_val <= '0;
    end else begin
      commit <= 1'b0;
      if (st == ST_READ) begin
        if (us_tick) gap <= (gap == GAP_LAST) ? '0 : gap + 1'b1;
        if (take) begin
          if (n != '0 && raw != ref_val) begin
            st  <= ST_WAIT;
            per <= '0;
          end else if (n == N_LAST) begin
            st         <= ST_WAIT;
            per        <= '0;
            commit     <= 1'b1;
            commit_val <= raw;
          end else begin
            if (n == '0) ref_val <= raw;
            n <= n + 1'b1;
          end
        end
      end else begin
        if (us_tick && per != PER_LAST) per <= per + 1'b1;
        if (per == PER_LAST && !any_detect) begin
          st  <= ST_READ;
          n   <= '0;
          gap <= '0;
        end
      end
    end
  end

  // R2
  sample_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    n <= N_LAST);

  // R4
  detect_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && any_detect) |=> st == ST_WAIT);

endmodule

// File: rtl/reset_pin_monitor.sv
module reset_pin_monitor #(
  parameter int MIN_LOW_US = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic rst_pin_n,
  output logic recal_all
);
  localparam int CW = $clog2(MIN_LOW_US + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW_US);

  logic [2:0]    s;
  logic [CW-1:0] low_cnt;
  logic          pu_pend;
  logic          rise;

  assign rise = s[1] & ~s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      s         <= 3'b111;
      low_cnt   <= '0;
      pu_pend   <= 1'b1;
      recal_all <= 1'b0;
    end else begin
      s       <= {s[1:0], rst_pin_n};
      pu_pend <= 1'b0;
      if (s[1])                             low_cnt <= '0;
      else if (us_tick && low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
      recal_all <= pu_pend | (rise & (low_cnt == CNT_MAX));
    end
  end

  // R9
  recal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    recal_all |=> !recal_all);

endmodule

// File: rtl/strap_option_sampler.sv
module strap_option_sampler
  import strap_pkg::*;
#(
  parameter int SAMPLES       = 25,
  parameter int SAMPLE_GAP_US = 10,
  parameter int REREAD_US     = 10_000_000,
  parameter int MIN_LOW_US    = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       us_tick,
  input  logic       strap_speed,
  input  logic       strap_tmo_a,
  input  logic       strap_tmo_b,
  input  logic       rst_pin_n,
  input  logic       any_detect,
  output logic       speed_slow,
  output logic [1:0] tmo_sel,
  output logic       toggle_en,
  output logic       opts_valid,
  output logic       recal_all
);
  raw_t  raw;
  raw_t  commit_val;
  logic  commit;
  opts_t opts_q;

  strap_sync #(.W(3), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({strap_speed, strap_tmo_a, strap_tmo_b}),
    .q   (raw)
  );

  strap_read_ctrl #(
    .SAMPLES       (SAMPLES),
    .SAMPLE_GAP_US (SAMPLE_GAP_US),
    .REREAD_US     (REREAD_US)
  ) u_read (
    .clk        (clk),
    .rst        (rst),
    .us_tick    (us_tick),
    .any_detect (any_detect),
    .raw        (raw),
    .commit     (commit),
    .commit_val (commit_val)
  );

  reset_pin_monitor #(.MIN_LOW_US(MIN_LOW_US)) u_rpin (
    .clk       (clk),
    .rst       (rst),
    .us_tick   (us_tick),
    .rst_pin_n (rst_pin_n),
    .recal_all (recal_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opts_q     <= '0;
      opts_valid <= 1'b0;
    end else if (commit) begin
      opts_q     <= decode_straps(commit_val);
      opts_valid <= 1'b1;
    end
  end

  assign speed_slow = opts_q.slow;
  assign tmo_sel    = opts_q.tmo;
  assign toggle_en  = opts_q.toggle;

  // R1
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    opts_valid |=> opts_valid);

  // R10
  opts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(opts_q));

  // R6
  toggle_tmo_chk: assert property (@(posedge clk) disable iff (rst)
    toggle_en |-> tmo_sel == 2'd0);

endmodule

// File: tb/tb_strap_option_sampler.sv
module tb_strap_option_sampler;
  localparam int SAMPLES = 4;
  localparam int GAP     = 2;
  localparam int REREAD  = 40;
  localparam int MINLOW  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, us_tick, strap_speed, a_val, strap_tmo_b, rst_pin_n, any_detect;
  logic speed_slow, toggle_en, opts_valid, recal_all;
  logic [1:0] tmo_sel;
  logic jit;
  logic jit_on;
  int   jc;
  int   tick_div;
  int   tick_cnt;
  int   rises, hi_cycles;
  logic prev_recal;
  int   nchk, nfail;

  strap_option_sampler #(
    .SAMPLES(SAMPLES), .SAMPLE_GAP_US(GAP), .REREAD_US(REREAD), .MIN_LOW_US(MINLOW)
  ) dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .strap_speed(strap_speed),
    .strap_tmo_a(a_val ^ jit), .strap_tmo_b(strap_tmo_b), .rst_pin_n(rst_pin_n),
    .any_detect(any_detect), .speed_slow(speed_slow), .tmo_sel(tmo_sel),
    .toggle_en(toggle_en), .opts_valid(opts_valid), .recal_all(recal_all)
  );

  initial begin
    us_tick = 1'b0; tick_cnt = 0; jit = 1'b0; jc = 0;
    rises = 0; hi_cycles = 0; prev_recal = 1'b0;
  end

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin us_tick = 1'b1; tick_cnt = 0; end
    else begin us_tick = 1'b0; tick_cnt = tick_cnt + 1; end
    if (jit_on) begin
      if (jc == 2) begin jc = 0; jit = ~jit; end else jc = jc + 1;
    end else begin
      jit = 1'b0; jc = 0;
    end
    if (recal_all) hi_cycles = hi_cycles + 1;
    if (recal_all && !prev_recal) rises = rises + 1;
    prev_recal = recal_all;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected decode from R5/R6
  task automatic check_combo(input int c, input string tag);
    int a, b, e_tmo;
    a = (c >> 1) & 1;
    b = c & 1;
    e_tmo = (a == 1) ? 0 : ((b == 1) ? 1 : 2);
    chk({tag, " R5 speed"}, int'(speed_slow), (c >> 2) & 1);
    chk({tag, " R6 tmo"}, int'(tmo_sel), e_tmo);
    chk({tag, " R6 toggle"}, int'(toggle_en), a & b);
  endtask

  task automatic set_combo(input int c);
    strap_speed = 1'((c >> 2) & 1);
    a_val       = 1'((c >> 1) & 1);
    strap_tmo_b = 1'(c & 1);
  endtask

  task automatic pin_pulse(input int len, input int exp, input string tag);
    int snap;
    snap = rises;
    rst_pin_n = 1'b0;
    wait_n(len);
    rst_pin_n = 1'b1;
    wait_n(20);
    chk(tag, rises - snap, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int snap_r, snap_h;
    rst = 1'b1; rst_pin_n = 1'b1; any_detect = 1'b0; tick_div = 1;
    jit_on = 1'b1;
    set_combo(6);
    wait_n(5);
    chk("R1 reset valid", int'(opts_valid), 0);
    chk("R1 reset recal", int'(recal_all), 0);
    snap_r = rises; snap_h = hi_cycles;
    rst = 1'b0;
    wait_n(100);
    chk("R8 power-up pulse count", rises - snap_r, 1);
    chk("R9 power-up pulse width", hi_cycles - snap_h, 1);
    chk("R1 R3 valid low under disagreement", int'(opts_valid), 0);
    jit_on = 1'b0;
    wait_n(150);
    chk("R1 valid after clean read", int'(opts_valid), 1);
    check_combo(6, "R2 first read");

    for (int c = 0; c < 8; c++) begin
      set_combo(c);
      wait_n(150);
      check_combo(c, "R4 sweep");
      chk("R1 valid sticky", int'(opts_valid), 1);
    end

    // detection blocks rereads (R4)
    any_detect = 1'b1;
    set_combo(0);
    wait_n(200);
    check_combo(7, "R4 held during detect");
    any_detect = 1'b0;
    wait_n(30);
    check_combo(0, "R4 read after detect clears");

    // disagreeing samples leave old options (R3, R10)
    set_combo(5);
    wait_n(150);
    check_combo(5, "R3 setup");
    jit_on = 1'b1;
    wait_n(100);
    check_combo(5, "R3 R10 mid disagreement");
    wait_n(100);
    check_combo(5, "R3 R10 end disagreement");
    jit_on = 1'b0;
    wait_n(150);
    check_combo(5, "R3 after disagreement");

    // reset pin (R7, R9)
    tick_div = 1;
    wait_n(5);
    pin_pulse(3, 0, "R7 short low ignored");
    pin_pulse(4, 1, "R7 low at threshold");
    snap_h = hi_cycles; snap_r = rises;
    pin_pulse(10, 1, "R7 long low");
    chk("R9 pin pulse width", hi_cycles - snap_h, rises - snap_r);
    tick_div = 3;
    wait_n(6);
    pin_pulse(6, 0, "R7 sparse ticks 2");
    pin_pulse(9, 0, "R7 sparse ticks 3");
    pin_pulse(12, 1, "R7 sparse ticks 4");
    pin_pulse(15, 1, "R7 sparse ticks 5");
    check_combo(5, "R10 options untouched by pin reset");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule